// File: doc/BRIEF.md
# Secondary Cache Tag and Line-State Directory

This block holds the tag and coherence state for every line of a direct-mapped, write-back, look-aside secondary cache that sits beside a pipelined host bus. Each processor bus cycle is looked up in one clock. The block decides whether the cycle is served from the cache, which it signals with a local-ready pulse, or is handed to the memory system, which it signals with a system-start pulse. It also reports whether the indexed line is dirty and whether the dirty line has to be written back first. Snoop cycles are looked up the same way and can invalidate a line.

Each line has a two-bit state. A processor read that misses with a four-word burst opens a pending fill. The line state is written when the system later strobes its first cacheable data word. The state is write-back or write-through depending on the system policy input at that moment and on the page write-through flag captured at the start of the cycle. Lock, pass-through and page write-through force writes to be handled as write-through. A locked read that finds a dirty line causes that line to be evicted and invalidated.

Top module: `sctag_dir`

## Requirements
- R1: While `rst` is high, every line becomes Invalid and all outputs are low. Any later lookup misses until a fill has completed.
- R2: The line index is address bits [LINE_OFF+IDX_W-1:LINE_OFF] and the tag is the next TAG_W bits. All outputs are registered: they are valid for exactly one cycle, starting at the clock edge that samples the strobe.
- R3: A memory read whose tag matches a non-Invalid line is a hit: `local_rdy`=1, `sys_start`=0, `lookup_hit`=1. A read miss gives `sys_start`=1.
- R4: A read miss with `burst_n`=0 (four words), `atomic_n`=1 and a cacheable address invalidates the indexed line and opens a pending fill. The first later clock with `fill_ok_n`=0 and no strobe writes the tag. The state becomes Exclusive (2'b10) if `sys_wb`=1 and `page_wt` was 0 at the start of the cycle; otherwise it becomes Shared (2'b01). Single-word reads never allocate. A new processor strobe before the fill cancels it.
- R5: A write that hits an Exclusive or Modified line with no forcing input is served locally (`local_rdy`=1). An Exclusive line then becomes Modified (2'b11).
- R6: A write with `atomic_n`=0, `pass_n`=0 or `page_wt`=1 goes to the system (`sys_start`=1) even on an Exclusive or Modified hit, and the line state is left unchanged.
- R7: Write misses and writes to Shared lines give `sys_start`=1 and leave the state unchanged. Writes never allocate.
- R8: A locked read (`atomic_n`=0) that hits a Modified line gives `evict`=1 and `sys_start`=1, and the line becomes Invalid. A locked read miss does not allocate.
- R9: An allocating read miss whose indexed victim line is Modified gives `evict`=1.
- R10: For a memory cycle with `burst_n`=0, `line_dirty` is 1 exactly when the indexed line is Modified, whether or not the tag matches. It is 0 for single-word cycles.
- R11: `snp_go_n`=0 starts a snoop, and a processor strobe in the same clock is ignored. A snoop hit on a Modified line gives `snp_dirty_hit`=1. With `snp_kill`=1 the hit line becomes Invalid, and with `snp_kill`=0 it is unchanged. Snoops never assert `local_rdy` or `sys_start`.
- R12: An I/O cycle (`is_mem`=0), or an address with any bit above the tag set, never hits, gives `sys_start`=1 and never allocates.
- R13: `local_rdy` and `sys_start` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_go_n | input | 1 | Processor cycle strobe, active low |
| snp_go_n | input | 1 | Snoop strobe, active low |
| snp_kill | input | 1 | Snoop invalidates the line when 1 |
| req_addr | input | ADDR_W-3 | Quad-word address bits [ADDR_W-1:3] |
| is_mem | input | 1 | 1 = memory cycle, 0 = I/O |
| is_write | input | 1 | 1 = write, 0 = read |
| burst_n | input | 1 | 0 = four-word cycle, 1 = single word |
| atomic_n | input | 1 | Locked cycle, active low |
| pass_n | input | 1 | Force write-through, active low |
| page_wt | input | 1 | Page write-through flag |
| sys_wb | input | 1 | System policy at fill: 1 = write-back |
| fill_ok_n | input | 1 | First cacheable fill word strobe, active low |
| local_rdy | output | 1 | Cycle served from the cache |
| sys_start | output | 1 | Cycle handed to the system |
| line_dirty | output | 1 | Indexed line is Modified |
| evict | output | 1 | Dirty line must be written back |
| lookup_hit | output | 1 | Processor lookup hit |
| snp_dirty_hit | output | 1 | Snoop hit a Modified line |

## Verification
The bench uses an 8-line directory. Every index is filled, with the system policy alternating and page write-through set on one index, so that Exclusive and Shared fills can be told apart. The difference shows in the reply to a later write: a local reply for Exclusive, a system start for Shared. The Modified state shows up on `line_dirty`. Each forcing input is applied on its own against the same Exclusive line, which separates a true override from a state change. Snoops, locked reads, victims that are dirty, out-of-range addresses, cancelled fills and a reset mid-run are then each followed by a read. That read shows whether the line survived, was invalidated or was never allocated.

// File: rtl/sctag_pkg.sv
package sctag_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_st_t;
endpackage

// File: rtl/sctag_store.sv
module sctag_store
  import sctag_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output line_st_t         rd_state,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_t         wr_state,
  input  logic             wr_tag_en,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  line_st_t         st_arr  [LINES];
  logic [TAG_W-1:0] tag_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) st_arr[g] <= LS_INV;
      else if (wr_en && wr_idx == IDX_W'(g)) st_arr[g] <= wr_state;
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_tag_en && wr_idx == IDX_W'(g)) tag_arr[g] <= wr_tag;
    end
  end

  assign rd_state = st_arr[rd_idx];
  assign rd_tag   = tag_arr[rd_idx];
endmodule

// File: rtl/sctag_decide.sv
module sctag_decide
  import sctag_pkg::*;
#(
  parameter int TAG_W = 10
) (
  input  logic             is_bus,
  input  logic             is_snp,
  input  logic             snp_kill,
  input  logic             is_mem,
  input  logic             is_write,
  input  logic             four_word,
  input  logic             atomic,
  input  logic             pass_force,
  input  logic             page_wt,
  input  logic             in_range,
  input  logic [TAG_W-1:0] req_tag,
  input  line_st_t         st,
  input  logic [TAG_W-1:0] st_tag,
  output logic             hit,
  output logic             go_local,
  output logic             go_sys,
  output logic             dirty,
  output logic             evict,
  output logic             upd_en,
  output line_st_t         upd_state,
  output logic             alloc,
  output logic             snp_hitm
);
  function automatic logic f_match(line_st_t s, logic [TAG_W-1:0] a,
                                   logic [TAG_W-1:0] b, logic rng);
    return (s != LS_INV) && (a == b) && rng;
  endfunction

  function automatic logic f_owned(line_st_t s);
    return (s == LS_EXC) || (s == LS_MOD);
  endfunction

  logic hit_c;
  logic wt_force;
  assign hit_c    = f_match(st, st_tag, req_tag, in_range);
  assign wt_force = atomic || pass_force || page_wt;

  always_comb begin
    hit = 1'b0; go_local = 1'b0; go_sys = 1'b0; dirty = 1'b0; evict = 1'b0;
    upd_en = 1'b0; upd_state = st; alloc = 1'b0; snp_hitm = 1'b0;
    if (is_snp) begin
      snp_hitm = hit_c && (st == LS_MOD);
      if (hit_c && snp_kill) begin
        upd_en = 1'b1; upd_state = LS_INV;
      end
    end else if (is_bus) begin
      dirty = is_mem && four_word && (st == LS_MOD);
      if (!is_mem || !in_range) begin
        go_sys = 1'b1;
      end else begin
        hit = hit_c;
        if (!is_write) begin
          if (atomic && hit_c && st == LS_MOD) begin
            evict = 1'b1; go_sys = 1'b1; upd_en = 1'b1; upd_state = LS_INV;
          end else if (hit_c) begin
            go_local = 1'b1;
          end else begin
            go_sys = 1'b1;
            if (four_word && !atomic) begin
              alloc = 1'b1; upd_en = 1'b1; upd_state = LS_INV;
              evict = (st == LS_MOD);
            end
          end
        end else if (hit_c && f_owned(st) && !wt_force) begin
          go_local = 1'b1;
          if (st == LS_EXC) begin
            upd_en = 1'b1; upd_state = LS_MOD;
          end
        end else begin
          go_sys = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sctag_fill.sv
module sctag_fill
  import sctag_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_seen,
  input  logic             strobe_any,
  input  logic             alloc,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             alloc_wt,
  input  logic             fill_ok_n,
  input  logic             sys_wb,
  output logic             fill_en,
  output logic [IDX_W-1:0] fill_idx,
  output logic [TAG_W-1:0] fill_tag,
  output line_st_t         fill_state
);
  logic pend_q;
  logic wt_q;

  function automatic line_st_t f_fill_state(logic wb, logic wt);
    return (wb && !wt) ? LS_EXC : LS_SHR;
  endfunction

  assign fill_en    = pend_q && !strobe_any && !fill_ok_n;
  assign fill_state = f_fill_state(sys_wb, wt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (alloc) begin
      pend_q <= 1'b1;
    end else if (bus_seen || fill_en) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      fill_idx <= alloc_idx;
      fill_tag <= alloc_tag;
      wt_q     <= alloc_wt;
    end
  end
endmodule

// File: rtl/sctag_dir.sv
module sctag_dir
  import sctag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 5,
  parameter int IDX_W    = 6,
  parameter int TAG_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_go_n,
  input  logic              snp_go_n,
  input  logic              snp_kill,
  input  logic [ADDR_W-1:3] req_addr,
  input  logic              is_mem,
  input  logic              is_write,
  input  logic              burst_n,
  input  logic              atomic_n,
  input  logic              pass_n,
  input  logic              page_wt,
  input  logic              sys_wb,
  input  logic              fill_ok_n,
  output logic              local_rdy,
  output logic              sys_start,
  output logic              line_dirty,
  output logic              evict,
  output logic              lookup_hit,
  output logic              snp_dirty_hit
);
  localparam int TAG_LO = LINE_OFF + IDX_W;
  localparam int TAG_HI = TAG_LO + TAG_W - 1;

  function automatic logic [IDX_W-1:0] f_idx(logic [ADDR_W-1:3] a);
    return a[TAG_LO-1:LINE_OFF];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(logic [ADDR_W-1:3] a);
    return a[TAG_HI:TAG_LO];
  endfunction
  function automatic logic f_in_range(logic [ADDR_W-1:3] a);
    return ~|a[ADDR_W-1:TAG_HI+1];
  endfunction

  logic             is_bus, is_snp;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             in_range;
  line_st_t         st;
  logic [TAG_W-1:0] st_tag;
  logic             hit_c, go_local, go_sys, dirty_c, evict_c, upd_en, alloc, snp_hitm;
  line_st_t         upd_state;
  logic             fill_en;
  logic [IDX_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_tag;
  line_st_t         fill_state;
  logic             wr_en, wr_tag_en;
  logic [IDX_W-1:0] wr_idx;
  line_st_t         wr_state;
  logic             addr_unused;

  assign is_snp      = !snp_go_n;
  assign is_bus      = !bus_go_n && snp_go_n;
  assign idx         = f_idx(req_addr);
  assign tag         = f_tag(req_addr);
  assign in_range    = f_in_range(req_addr);
  assign addr_unused = ^req_addr[LINE_OFF-1:3];

  sctag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst), .rd_idx(idx), .rd_state(st), .rd_tag(st_tag),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state),
    .wr_tag_en(wr_tag_en), .wr_tag(fill_tag)
  );

  sctag_decide #(.TAG_W(TAG_W)) u_decide (
    .is_bus(is_bus), .is_snp(is_snp), .snp_kill(snp_kill), .is_mem(is_mem),
    .is_write(is_write), .four_word(!burst_n), .atomic(!atomic_n),
    .pass_force(!pass_n), .page_wt(page_wt), .in_range(in_range),
    .req_tag(tag), .st(st), .st_tag(st_tag), .hit(hit_c),
    .go_local(go_local), .go_sys(go_sys), .dirty(dirty_c), .evict(evict_c),
    .upd_en(upd_en), .upd_state(upd_state), .alloc(alloc), .snp_hitm(snp_hitm)
  );

  sctag_fill #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_fill (
    .clk(clk), .rst(rst), .bus_seen(is_bus), .strobe_any(is_bus || is_snp),
    .alloc(alloc), .alloc_idx(idx), .alloc_tag(tag), .alloc_wt(page_wt),
    .fill_ok_n(fill_ok_n), .sys_wb(sys_wb), .fill_en(fill_en),
    .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_state(fill_state)
  );

  // Lookup updates and fills never share a cycle: a fill waits for a strobe-free clock.
  assign wr_en     = upd_en || fill_en;
  assign wr_idx    = upd_en ? idx : fill_idx;
  assign wr_state  = upd_en ? upd_state : fill_state;
  assign wr_tag_en = fill_en && !upd_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      local_rdy <= 1'b0; sys_start <= 1'b0; line_dirty <= 1'b0;
      evict <= 1'b0; lookup_hit <= 1'b0; snp_dirty_hit <= 1'b0;
    end else begin
      local_rdy     <= go_local;
      sys_start     <= go_sys;
      line_dirty    <= dirty_c;
      evict         <= evict_c;
      lookup_hit    <= hit_c;
      snp_dirty_hit <= snp_hitm;
    end
  end
endmodule

// File: rtl/sctag_dir_chk.sv
module sctag_dir_chk (
  input logic clk,
  input logic rst,
  input logic bus_go_n,
  input logic snp_go_n,
  input logic is_mem,
  input logic burst_n,
  input logic local_rdy,
  input logic sys_start,
  input logic line_dirty,
  input logic evict,
  input logic snp_dirty_hit,
  input logic fill_en,
  input logic upd_en
);
  p_one_path_r13: assert property (@(posedge clk) disable iff (rst)
    !(local_rdy && sys_start));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_go_n) && $past(snp_go_n)) |-> (!local_rdy && !sys_start && !evict));

  p_snoop_silent_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!snp_go_n) |-> (!local_rdy && !sys_start));

  p_hitm_from_snoop_r11: assert property (@(posedge clk) disable iff (rst)
    snp_dirty_hit |-> $past(!snp_go_n));

  p_evict_to_sys_r8: assert property (@(posedge clk) disable iff (rst)
    evict |-> sys_start);

  p_dirty_burst_mem_r10: assert property (@(posedge clk) disable iff (rst)
    line_dirty |-> ($past(is_mem) && !$past(burst_n)));

  p_one_writer_r4: assert property (@(posedge clk) disable iff (rst)
    !(fill_en && upd_en));
endmodule

bind sctag_dir sctag_dir_chk u_chk (
  .clk(clk), .rst(rst), .bus_go_n(bus_go_n), .snp_go_n(snp_go_n),
  .is_mem(is_mem), .burst_n(burst_n), .local_rdy(local_rdy),
  .sys_start(sys_start), .line_dirty(line_dirty), .evict(evict),
  .snp_dirty_hit(snp_dirty_hit), .fill_en(fill_en), .upd_en(upd_en)
);

// File: tb/sctag_dir_bench.sv
module sctag_dir_bench;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_go_n = 1'b1, snp_go_n = 1'b1, snp_kill = 1'b0;
  logic [31:3] req_addr = '0;
  logic is_mem = 1'b1, is_write = 1'b0, burst_n = 1'b0, atomic_n = 1'b1;
  logic pass_n = 1'b1, page_wt = 1'b0, sys_wb = 1'b0, fill_ok_n = 1'b1;
  logic local_rdy, sys_start, line_dirty, evict, lookup_hit, snp_dirty_hit;
  logic o_rdy, o_start, o_dirty, o_evict, o_hit, o_shit;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sctag_dir #(.IDX_W(IDX_W)) u_sctag_dir (
    .clk(clk), .rst(rst), .bus_go_n(bus_go_n), .snp_go_n(snp_go_n),
    .snp_kill(snp_kill), .req_addr(req_addr), .is_mem(is_mem),
    .is_write(is_write), .burst_n(burst_n), .atomic_n(atomic_n),
    .pass_n(pass_n), .page_wt(page_wt), .sys_wb(sys_wb), .fill_ok_n(fill_ok_n),
    .local_rdy(local_rdy), .sys_start(sys_start), .line_dirty(line_dirty),
    .evict(evict), .lookup_hit(lookup_hit), .snp_dirty_hit(snp_dirty_hit)
  );

  function automatic logic [31:0] mk(int idx, int tg);
    return (32'(tg) << (5 + IDX_W)) | (32'(idx) << 5);
  endfunction

  task automatic chk(input string rq, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, got, exp);
    end
  endtask

  task automatic grab();
    o_rdy = local_rdy; o_start = sys_start; o_dirty = line_dirty;
    o_evict = evict; o_hit = lookup_hit; o_shit = snp_dirty_hit;
    chk("R13", "rdy and start together", int'(o_rdy && o_start), 0);
  endtask

  task automatic bus(input logic [31:0] a, input logic w, input logic bn,
                     input logic an = 1'b1, input logic pn = 1'b1,
                     input logic pw = 1'b0, input logic m = 1'b1);
    @(negedge clk);
    req_addr = a[31:3]; is_write = w; burst_n = bn; atomic_n = an;
    pass_n = pn; page_wt = pw; is_mem = m; bus_go_n = 1'b0;
    @(negedge clk);
    bus_go_n = 1'b1; atomic_n = 1'b1; pass_n = 1'b1; page_wt = 1'b0; is_mem = 1'b1;
    grab();
  endtask

  task automatic fill(input logic wb);
    @(negedge clk); fill_ok_n = 1'b0; sys_wb = wb;
    @(negedge clk); fill_ok_n = 1'b1;
  endtask

  task automatic snoop(input logic [31:0] a, input logic kill,
                       input logic with_bus = 1'b0, input logic w = 1'b0);
    @(negedge clk);
    req_addr = a[31:3]; snp_kill = kill; snp_go_n = 1'b0;
    if (with_bus) begin bus_go_n = 1'b0; is_write = w; burst_n = 1'b0; end
    @(negedge clk);
    snp_go_n = 1'b1; bus_go_n = 1'b1; snp_kill = 1'b0;
    grab();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "rdy in reset", int'(local_rdy), 0);
    chk("R1", "start in reset", int'(sys_start), 0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bus(mk(i, 1), 1'b0, 1'b1);
      chk("R1", "post-reset miss start", int'(o_start), 1);
      chk("R1", "post-reset no hit", int'(o_hit), 0);
    end

    // Fill every index; policy alternates, index 6 carries page write-through.
    for (int i = 0; i < 8; i++) begin
      logic pw, swb, exp_e;
      pw = (i == 6); swb = i[0]; exp_e = swb && !pw;
      bus(mk(i, i + 1), 1'b0, 1'b0, 1'b1, 1'b1, pw);
      chk("R3", "read miss start", int'(o_start), 1);
      chk("R9", "clean victim no evict", int'(o_evict), 0);
      fill(swb);
      bus(mk(i, i + 1), 1'b0, 1'b1);
      chk("R4", "filled line hits", int'(o_rdy && o_hit), 1);
      if (i < 4) begin
        bus(mk(i, i + 1), 1'b1, 1'b0);
        chk("R5", "write owned local", int'(o_rdy), int'(exp_e));
        chk("R7", "write shared to system", int'(o_start), int'(!exp_e));
        bus(mk(i, i + 1), 1'b0, 1'b0);
        chk("R5", "exclusive became modified", int'(o_dirty), int'(exp_e));
      end else begin
        bus(mk(i, i + 1), 1'b0, 1'b0);
        chk("R10", "clean line not dirty", int'(o_dirty), 0);
      end
    end
    @(negedge clk);
    chk("R2", "rdy pulse one cycle", int'(local_rdy), 0);

    // Single-word read does not allocate; tag aliasing on same index.
    bus(mk(0, 20), 1'b0, 1'b1);
    chk("R2", "other tag same index misses", int'(o_start), 1);
    fill(1'b1);
    bus(mk(0, 1), 1'b0, 1'b1);
    chk("R4", "single-word miss kept old line", int'(o_rdy), 1);

    // Forcing inputs on exclusive index 5.
    bus(mk(5, 6), 1'b1, 1'b0, 1'b0);
    chk("R6", "locked write to system", int'(o_start && !o_rdy), 1);
    bus(mk(5, 6), 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6", "pass-through write to system", int'(o_start), 1);
    bus(mk(5, 6), 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R6", "page wt write to system", int'(o_start), 1);
    bus(mk(5, 6), 1'b0, 1'b0);
    chk("R6", "state unchanged after forced writes", int'(o_dirty), 0);
    bus(mk(5, 6), 1'b1, 1'b0);
    chk("R5", "plain write local", int'(o_rdy), 1);
    bus(mk(5, 6), 1'b0, 1'b0);
    chk("R5", "now modified", int'(o_dirty), 1);

    // Write misses and shared writes.
    bus(mk(7, 30), 1'b1, 1'b0);
    chk("R7", "write miss to system", int'(o_start && !o_rdy), 1);
    bus(mk(7, 8), 1'b0, 1'b0);
    chk("R7", "write miss no allocate", int'(o_rdy && !o_dirty), 1);
    bus(mk(4, 5), 1'b1, 1'b0);
    chk("R7", "shared write to system", int'(o_start), 1);
    bus(mk(4, 5), 1'b0, 1'b0);
    chk("R7", "shared unchanged", int'(o_rdy && !o_dirty), 1);

    // Dirty indication on modified index 1.
    bus(mk(1, 40), 1'b1, 1'b0);
    chk("R10", "dirty on miss", int'(o_dirty), 1);
    bus(mk(1, 2), 1'b0, 1'b1);
    chk("R10", "single word not dirty", int'(o_dirty), 0);
    bus(mk(1, 2), 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R12", "io to system", int'(o_start && !o_rdy && !o_hit), 1);
    chk("R10", "io not dirty", int'(o_dirty), 0);

    // Locked read of modified line.
    bus(mk(1, 2), 1'b0, 1'b0, 1'b0);
    chk("R8", "locked dirty evict", int'(o_evict && o_start && !o_rdy), 1);
    bus(mk(1, 2), 1'b0, 1'b0, 1'b0);
    chk("R8", "line invalidated", int'(o_start && !o_evict), 1);
    fill(1'b1);
    bus(mk(1, 2), 1'b0, 1'b1);
    chk("R8", "locked miss no allocate", int'(o_start), 1);

    // Dirty victim on allocating read (index 3 is modified).
    bus(mk(3, 50), 1'b0, 1'b0);
    chk("R9", "dirty victim evict", int'(o_evict && o_start), 1);
    fill(1'b0);
    bus(mk(3, 50), 1'b0, 1'b1);
    chk("R4", "new line hits", int'(o_rdy), 1);
    bus(mk(3, 50), 1'b1, 1'b0);
    chk("R4", "low policy gives shared", int'(o_start), 1);
    bus(mk(3, 4), 1'b0, 1'b1);
    chk("R9", "old line gone", int'(o_start), 1);

    // Snoops.
    snoop(mk(5, 6), 1'b0);
    chk("R11", "snoop dirty hit", int'(o_shit), 1);
    bus(mk(5, 6), 1'b0, 1'b1);
    chk("R11", "plain snoop keeps line", int'(o_rdy), 1);
    snoop(mk(5, 6), 1'b1);
    chk("R11", "kill snoop dirty hit", int'(o_shit), 1);
    bus(mk(5, 6), 1'b0, 1'b1);
    chk("R11", "kill snoop invalidated", int'(o_start), 1);
    snoop(mk(7, 8), 1'b0, 1'b1, 1'b1);
    chk("R11", "bus strobe ignored", int'(o_rdy || o_start || o_shit), 0);
    bus(mk(7, 8), 1'b0, 1'b0);
    chk("R11", "ignored write left exclusive", int'(o_rdy && !o_dirty), 1);
    snoop(mk(7, 99), 1'b1);
    chk("R11", "snoop miss no hit", int'(o_shit), 0);
    bus(mk(7, 8), 1'b0, 1'b1);
    chk("R11", "snoop miss kept line", int'(o_rdy), 1);

    // Out-of-range address.
    bus(mk(7, 8) | 32'h8000_0000, 1'b0, 1'b0);
    chk("R12", "out of range to system", int'(o_start && !o_hit && !o_rdy), 1);
    fill(1'b1);
    bus(mk(7, 8), 1'b0, 1'b1);
    chk("R12", "out of range no allocate", int'(o_rdy), 1);

    // Pending fill cancelled by a new strobe.
    bus(mk(2, 60), 1'b0, 1'b0);
    chk("R4", "allocating miss", int'(o_start), 1);
    bus(mk(0, 1), 1'b0, 1'b1);
    fill(1'b1);
    bus(mk(2, 60), 1'b0, 1'b1);
    chk("R4", "cancelled fill not written", int'(o_start), 1);

    // Reset mid-run.
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "outputs low in reset", int'(local_rdy || sys_start || line_dirty), 0);
    rst = 1'b0;
    bus(mk(0, 1), 1'b0, 1'b1);
    chk("R1", "reset invalidates", int'(o_start && !o_hit), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule